// File: doc/BRIEF.md
# Three-Channel Cascadable Interval Timer

The block holds three 16-bit down-counting interval timers that share one prescaled tick. Software loads each timer's reload latch through a byte-wide register port, releases a global hold bit, and then receives a periodic flag per timer: a counter loaded with N runs for N+1 ticks, raises its flag, reloads itself from its latch and continues without any further access. Timers one and three count the prescaled tick directly. Timer two counts the expiries of timer three, so the pair forms one 32-bit countdown.

Each 16-bit quantity crosses the 8-bit port in two accesses. A latch write goes high byte first into a holding buffer, and the low-byte write commits all sixteen bits together. A counter read goes high byte first, which also freezes the low byte for the read that follows, so the two halves come from the same cycle. A flag is cleared by reading the status register while the flag is set and then reading that timer's counter. The interrupt output is high whenever an enabled timer has its flag set.

Top module: `timer_bank`

## Requirements
- R1: After rst_n is released the hold bit (control 1 bit 0) is 1, every latch and counter reads 0xFFFF, the status register reads 0x00 and irq is 0.
- R2: The prescaler issues one tick every PRESCALE clock cycles and stays cleared while hold is 1, so timers one and three decrement at most once per PRESCALE cycles.
- R3: A running counter holding N reaches zero after N ticks and on the next tick (tick N+1) it expires, reloads the current latch value and keeps counting.
- R4: Timer two steps once per expiry of timer three and never on a prescaler tick, so the pair counts (L3+1)*(L2+1) ticks between expiries of timer two.
- R5: A write to a latch high address (2, 4 or 6 for timers 1, 2, 3) only fills a shared buffer; a write to the next odd address (3, 5, 7) loads buffer and data together as {buffer, data} into that timer's latch.
- R6: A read of a counter high address returns bits 15:8 of that counter and captures bits 7:0, which the following read of the odd address returns.
- R7: The status register at address 1 reads {irq, 0000, flag3, flag2, flag1}; irq equals (flag1 AND control 1 bit 6) OR (flag2 AND control 2 bit 6) OR (flag3 AND control 3 bit 6).
- R8: An expiry sets the timer's flag; the flag clears only on a counter high-byte read that follows a status read during which that flag was set; a set and a clear in the same cycle leave the flag set.
- R9: While hold is 1 every counter follows its latch one cycle later and all flags read 0.
- R10: A write to address 0 goes to control 1 when control 2 bit 0 is 1 and to control 3 when it is 0; a write to address 1 goes to control 2; reads of address 0 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rd | input | 1 | Read strobe; read side effects act on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high, 0 otherwise |
| irq | output | 1 | Interrupt request, OR of enabled flags |

## Verification
The bench builds the block with PRESCALE set to 3 instead of the default 100, which brings a tick every three cycles and so lets dozens of expiries of timers one and three, and several cascaded expiries of timer two, happen within a few thousand cycles. Short latch values (5, 1 and 2) exercise reload and the cascade often, while a latch above 255 makes the high byte change between reads so the low-byte capture is tested. With this setting the reference model meets flag-set, clear-sequence and hold transitions at many different prescaler phases.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 16;
    localparam int NUM_TMR = 3;
    localparam int ADDR_W  = 3;

    // timer 2 counts the expiries of this timer
    localparam int CASCADE_SRC = 2;
    localparam int CASCADE_DST = 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd1;

    localparam int IE_BIT   = 6;
    localparam int HOLD_BIT = 0;
    localparam int SEL_BIT  = 0;

    localparam logic [CNT_W-1:0] LATCH_RST = {CNT_W{1'b1}};

    typedef logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec_t;

    typedef struct packed {
        logic               hold;     // control 1 bit 0
        logic [NUM_TMR-1:0] ie;       // bit 6 of controls 1..3
        logic               sel_c1;   // control 2 bit 0
        logic [BYTE_W-1:0]  hi_buf;   // pending latch high byte
        logic [BYTE_W-1:0]  snap;     // captured counter low byte
        cnt_vec_t           latch;
        logic [NUM_TMR-1:0] flag;
        logic [NUM_TMR-1:0] armed;    // flag seen set by a status read
    } bank_regs_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        tick  = !hold && (div_q == LAST);
        div_d = div_q + 1'b1;
        if (hold || tick) begin
            div_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         zero
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (hold) begin
            count_d = reload_val;
        end else if (step) begin
            if (count_q == '0) begin
                count_d = reload_val;
            end else begin
                count_d = count_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= {W{1'b1}};
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
    assign zero  = (count_q == '0);
endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import timer_bank_pkg::*;
#(
    parameter int PRESCALE = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    bank_regs_t r_d, r_q;

    logic               tick_w;
    logic               hold_w;
    logic [NUM_TMR-1:0] zero_w;
    logic [NUM_TMR-1:0] step_w;
    logic [NUM_TMR-1:0] expire_w;
    cnt_vec_t           count_w;
    cnt_vec_t           latch_w;
    logic [NUM_TMR-1:0] flag_w;
    logic               irq_w;

    assign hold_w  = r_q.hold;
    assign latch_w = r_q.latch;
    assign flag_w  = r_q.flag;

    tmr_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold_w),
        .tick  (tick_w)
    );

    // step sources: the cascade target follows the source's expiry
    always_comb begin
        for (int i = 0; i < NUM_TMR; i++) begin
            if (i != CASCADE_DST) begin
                step_w[i]   = tick_w;
                expire_w[i] = tick_w && zero_w[i];
            end
        end
        step_w[CASCADE_DST]   = expire_w[CASCADE_SRC];
        expire_w[CASCADE_DST] = expire_w[CASCADE_SRC] && zero_w[CASCADE_DST];
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tmr_down_counter #(.W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold       (hold_w),
            .step       (step_w[g]),
            .reload_val (r_q.latch[g]),
            .count      (count_w[g]),
            .zero       (zero_w[g])
        );
    end

    assign irq_w = |(r_q.flag & r_q.ie);
    assign irq   = irq_w;

    // read data path
    always_comb begin
        logic [1:0] idx;
        idx       = bus_addr[2:1] - 2'd1;
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_STATUS) begin
                bus_rdata = {irq_w, {(BYTE_W-1-NUM_TMR){1'b0}}, r_q.flag};
            end else if (bus_addr != ADDR_CTRL) begin
                if (!bus_addr[0]) begin
                    bus_rdata = count_w[idx][CNT_W-1:BYTE_W];
                end else begin
                    bus_rdata = r_q.snap;
                end
            end
        end
    end

    // next-state logic
    always_comb begin
        logic [1:0]         idx;
        logic               tmr_addr;
        logic [NUM_TMR-1:0] clr;
        idx      = bus_addr[2:1] - 2'd1;
        tmr_addr = (bus_addr != ADDR_CTRL) && (bus_addr != ADDR_STATUS);
        r_d      = r_q;

        for (int i = 0; i < NUM_TMR; i++) begin
            clr[i] = bus_rd && tmr_addr && !bus_addr[0] &&
                     (int'(idx) == i) && r_q.armed[i];
        end

        // flags and their clear-sequence arming
        for (int i = 0; i < NUM_TMR; i++) begin
            if (hold_w) begin
                r_d.flag[i]  = 1'b0;
                r_d.armed[i] = 1'b0;
            end else begin
                if (expire_w[i]) begin
                    r_d.flag[i] = 1'b1;
                end else if (clr[i]) begin
                    r_d.flag[i] = 1'b0;
                end
                if (bus_rd && bus_addr == ADDR_STATUS) begin
                    r_d.armed[i] = r_q.flag[i];
                end else if (clr[i]) begin
                    r_d.armed[i] = 1'b0;
                end
            end
        end

        // counter low-byte capture on a high-byte read
        if (bus_rd && tmr_addr && !bus_addr[0]) begin
            r_d.snap = count_w[idx][BYTE_W-1:0];
        end

        // register writes
        if (bus_wr) begin
            if (bus_addr == ADDR_CTRL) begin
                if (r_q.sel_c1) begin
                    r_d.hold  = bus_wdata[HOLD_BIT];
                    r_d.ie[0] = bus_wdata[IE_BIT];
                end else begin
                    r_d.ie[2] = bus_wdata[IE_BIT];
                end
            end else if (bus_addr == ADDR_STATUS) begin
                r_d.sel_c1 = bus_wdata[SEL_BIT];
                r_d.ie[1]  = bus_wdata[IE_BIT];
            end else if (!bus_addr[0]) begin
                r_d.hi_buf = bus_wdata;
            end else begin
                r_d.latch[idx] = {r_q.hi_buf, bus_wdata};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.hold   <= 1'b1;
            r_q.ie     <= '0;
            r_q.sel_c1 <= 1'b0;
            r_q.hi_buf <= '0;
            r_q.snap   <= '0;
            r_q.latch  <= {NUM_TMR{LATCH_RST}};
            r_q.flag   <= '0;
            r_q.armed  <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
    import timer_bank_pkg::*;
#(
    parameter int PRESCALE = 100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hold,
    input logic               tick,
    input logic [NUM_TMR-1:0] expire,
    input logic [NUM_TMR-1:0] flag,
    input cnt_vec_t           count,
    input cnt_vec_t           latch,
    input logic               irq
);
    a_r2_no_tick_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !tick);

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESCALE > 1) && tick |=> !tick);

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !hold && count[0] != '0 |=> count[0] == $past(count[0]) - 1'b1);

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |=> count[0] == $past(latch[0]));

    a_r4_cascade_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hold && !expire[CASCADE_SRC] |=> $stable(count[CASCADE_DST]));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((flag & $past(expire)) == $past(expire)));

    a_r9_hold_preset: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> count[2] == $past(latch[2]) && flag == '0);

    a_r1_quiet_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold && $past(hold) |-> !irq);
endmodule

bind timer_bank timer_bank_chk #(.PRESCALE(PRESCALE)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold_w),
    .tick   (tick_w),
    .expire (expire_w),
    .flag   (flag_w),
    .count  (count_w),
    .latch  (latch_w),
    .irq    (irq)
);

// File: tb/test_timer_bank.sv
module test_timer_bank;
    localparam int P = 3;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq;

    always #4 clk = ~clk;

    timer_bank #(.PRESCALE(P)) i_timer_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference state
    int m_cnt[3];
    int m_lat[3];
    int m_c1, m_c2, m_c3;
    int m_buf, m_snap, m_pre;
    bit m_flag[3];
    bit m_arm[3];

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    function automatic void m_reset();
        for (int i = 0; i < 3; i++) begin
            m_cnt[i] = 16'hFFFF; m_lat[i] = 16'hFFFF;
            m_flag[i] = 0; m_arm[i] = 0;
        end
        m_c1 = 1; m_c2 = 0; m_c3 = 0;
        m_buf = 0; m_snap = 0; m_pre = 0;
    endfunction

    function automatic bit m_irq();
        return (m_flag[0] && m_c1[6]) || (m_flag[1] && m_c2[6]) || (m_flag[2] && m_c3[6]);
    endfunction

    function automatic int m_read(int a);
        if (a == 0) return 0;
        if (a == 1) return (int'(m_irq()) << 7) | (int'(m_flag[2]) << 2) |
                           (int'(m_flag[1]) << 1) | int'(m_flag[0]);
        if (a % 2 == 0) return m_cnt[a/2 - 1] >> 8;
        return m_snap;
    endfunction

    function automatic void m_step(bit w, bit r, int a, int d);
        bit hold, tick;
        bit e[3];
        bit st[3];
        bit clr[3];
        int nc[3];
        hold  = m_c1[0];
        tick  = !hold && (m_pre == P - 1);
        e[0]  = tick && m_cnt[0] == 0;
        e[2]  = tick && m_cnt[2] == 0;
        e[1]  = e[2] && m_cnt[1] == 0;
        st[0] = tick; st[2] = tick; st[1] = e[2];
        for (int i = 0; i < 3; i++) begin
            if (hold) nc[i] = m_lat[i];
            else if (st[i]) nc[i] = (m_cnt[i] == 0) ? m_lat[i] : m_cnt[i] - 1;
            else nc[i] = m_cnt[i];
            clr[i] = r && (a == 2 + 2*i) && m_arm[i];
        end
        if (r && a >= 2 && a % 2 == 0) m_snap = m_cnt[a/2 - 1] & 255;
        for (int i = 0; i < 3; i++) begin
            bit of;
            of = m_flag[i];
            if (hold) begin
                m_flag[i] = 0; m_arm[i] = 0;
            end else begin
                if (e[i]) m_flag[i] = 1;
                else if (clr[i]) m_flag[i] = 0;
                if (r && a == 1) m_arm[i] = of;
                else if (clr[i]) m_arm[i] = 0;
            end
            m_cnt[i] = nc[i];
        end
        m_pre = (hold || tick) ? 0 : m_pre + 1;
        if (w) begin
            if (a == 0) begin
                if (m_c2[0]) m_c1 = d; else m_c3 = d;
            end else if (a == 1) m_c2 = d;
            else if (a % 2 == 0) m_buf = d;
            else m_lat[a/2 - 1] = (m_buf << 8) | d;
        end
    endfunction

    // one bus cycle; irq compared every cycle against the model (R7)
    task automatic op(bit w, bit r, int a, int d, string tag, output int got);
        @(negedge clk);
        check("R7 irq", int'(irq), int'(m_irq()));
        bus_wr = w; bus_rd = r; bus_addr = 3'(a); bus_wdata = 8'(d);
        #1;
        got = bus_rdata;
        if (r) check(tag, int'(bus_rdata), m_read(a));
        @(posedge clk);
        m_step(w, r, a, d);
        cycles++;
    endtask

    task automatic wr(int a, int d);
        int g;
        op(1, 0, a, d, "R10 write", g);
    endtask

    task automatic rd(int a, string tag, output int got);
        op(0, 1, a, 0, tag, got);
    endtask

    task automatic idle(int n);
        int g;
        for (int k = 0; k < n; k++) op(0, 0, 0, 0, "idle", g);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            if (cycles > WATCHDOG) begin
                fails++; checks++;
                $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        int v;
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        rst_n = 1'b0;
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 irq", int'(irq), 0);
        rd(1, "R1 status", v);    check("R1 status", v, 8'h00);
        rd(2, "R1 cnt1 hi", v);   check("R1 cnt1 hi", v, 8'hFF);
        rd(3, "R6 cnt1 lo", v);   check("R1 cnt1 lo", v, 8'hFF);
        rd(6, "R1 cnt3 hi", v);   check("R1 cnt3 hi", v, 8'hFF);
        rd(0, "R10 ctrl read", v); check("R10 ctrl read", v, 8'h00);

        // R5: load latches in hold, t1=5, t2=1, t3=2
        wr(2, 8'h00); wr(3, 8'h05);
        wr(4, 8'h00); wr(5, 8'h01);
        wr(6, 8'h00); wr(7, 8'h02);
        idle(2);
        rd(2, "R5 cnt1 hi", v); check("R5 cnt1 hi", v, 8'h00);
        rd(3, "R5 cnt1 lo", v); check("R5 cnt1 lo", v, 8'h05);
        // R5: a high-byte write alone leaves the latch unchanged
        wr(2, 8'h12);
        idle(3);
        rd(2, "R5 hi-only", v); check("R5 hi-only hi", v, 8'h00);
        rd(3, "R5 hi-only", v); check("R5 hi-only lo", v, 8'h05);
        wr(2, 8'h00); wr(3, 8'h05);

        // R10: route control writes, enable all three, release hold
        wr(1, 8'h41);            // select control 1, ie2
        wr(0, 8'h40);            // run, ie1
        wr(1, 8'h40);            // select control 3
        wr(0, 8'h40);            // ie3
        for (int k = 0; k < 40; k++) begin
            rd(2, "R3 cnt1 hi", v);
            rd(3, "R2 cnt1 lo", v);
            rd(6, "R4 cnt3 hi", v);
            rd(7, "R3 cnt3 lo", v);
            rd(4, "R4 cnt2 hi", v);
            rd(5, "R4 cnt2 lo", v);
            idle(k % 5);
        end

        // R8: clear sequences and counter reads without a prior status read
        for (int k = 0; k < 30; k++) begin
            rd(1, "R7 status", v);
            rd(2 + 2 * (k % 3), "R8 clear read", v);
            rd(1, "R8 status after", v);
            idle(k % 7);
            rd(2 + 2 * ((k + 1) % 3), "R8 read no status", v);
            rd(1, "R8 status", v);
        end

        // R10: disable ie3 through the shared address
        wr(0, 8'h00);
        idle(30);
        rd(1, "R10 status", v);

        // R9: hold via control 1
        wr(1, 8'h01);
        wr(0, 8'h01);
        idle(4);
        rd(1, "R9 status", v);  check("R9 status", v, 8'h00);
        rd(4, "R9 cnt2 hi", v); check("R9 cnt2 hi", v, 8'h00);
        rd(5, "R9 cnt2 lo", v); check("R9 cnt2 lo", v, 8'h01);

        // R6: wide latch so the high byte changes while running
        wr(2, 8'h01); wr(3, 8'h02);
        wr(6, 8'h00); wr(7, 8'h03);
        wr(4, 8'h00); wr(5, 8'h02);
        wr(0, 8'h40);            // run, ie1
        for (int k = 0; k < 150; k++) begin
            rd(2, "R6 cnt1 hi", v);
            idle(k % 4);
            rd(3, "R6 cnt1 lo", v);
            rd(1, "R4 status", v);
            rd(4, "R8 cnt2 hi", v);
        end
        idle(50);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule